// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Set

This block holds the software-visible control state of one channel of a bus-master disk DMA engine. Software reaches it through a byte-addressed register port that takes accesses of one, two or four bytes. The block keeps a command byte (run bit and transfer direction), a status byte (capability flags, interrupt, error and active indication) and a word-aligned pointer to the descriptor table in memory.

When software sets the run bit, the block raises a one-cycle start pulse toward the drive side, with the current table pointer presented beside it. When software clears the run bit, it raises a one-cycle abort pulse. The drive side reports back with a completion strobe, which ends the run and raises the interrupt flag, and with a plain interrupt strobe. Walking the descriptor table, moving data and the device's configuration space belong to other blocks.

Top module: `bmdma_chan_regs`

## Requirements
- R1: After reset the command byte reads 0x00, the status byte reads 0x60 (both capability flags set), the two spare bytes read 0x00 and the table pointer reads 0x00000000.
- R2: A read returns, little-endian, the bytes of the 8-byte register image starting at the access address (byte 0 command, byte 1 spare, byte 2 status, byte 3 spare, bytes 4 to 7 pointer), for sizes 1, 2 and 4; a read of another size or one that runs past byte 7 returns 0. Unused upper bytes read 0.
- R3: In the command byte, bit 0 is the run bit and bit 3 the direction; other bits read 0. A 1-byte write at offset 0 that turns the run bit from 0 to 1 while a drive is present sets the active flag (status bit 0) and raises dma_start for exactly one cycle, registered, with dma_ptr equal to the table pointer.
- R4: A command write that turns the run bit from 1 to 0 clears the active flag and raises dma_abort for exactly one cycle, registered.
- R5: While the run bit is 1, a command write leaves the direction bit unchanged.
- R6: In the status byte, bit 0 (active) cannot be written by software; bits 2 (interrupt) and 1 (DMA error) clear only when written with 1 and are unchanged by a 0; bits 6 and 5 (capability flags for drive 0 and drive 1) are plain read/write; bits 7, 4 and 3 read 0.
- R7: A 4-byte write at offset 4 loads the table pointer with bits 1:0 forced to 0.
- R8: A completion strobe clears the run bit and the active flag and sets the interrupt flag, without an abort pulse.
- R9: An interrupt strobe sets the interrupt flag; when a strobe and a software write of 1 to the interrupt bit meet in one cycle, the flag stays set.
- R10: While bus-master enable is low, writes change nothing and raise no error; reads still return the registers.
- R11: A write other than 1 byte at offsets 0 to 3 or 4 bytes at offset 4 raises acc_err for one cycle and changes nothing; a run request while no drive is present raises acc_err, leaves the run bit 0 and gives no start pulse.
- R12: The spare bytes at offsets 1 and 3 hold what a 1-byte write puts there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bm_en | input | 1 | Bus-master enable; writes are dropped while low |
| drive_present | input | 1 | A drive is attached to the selected position |
| acc_addr | input | 3 | Byte offset of the access |
| acc_size | input | 3 | Access width in bytes (1, 2 or 4) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data, little-endian from the access offset |
| rd_data | output | 32 | Read data for the current address and size |
| done_strobe | input | 1 | Transfer completion from the drive side |
| intr_strobe | input | 1 | Interrupt request from the drive side |
| dma_start | output | 1 | One-cycle start request |
| dma_abort | output | 1 | One-cycle abort request |
| dma_ptr | output | 32 | Descriptor table pointer |
| dma_dir | output | 1 | Transfer direction |
| acc_err | output | 1 | One-cycle illegal-write or no-drive error |

## Verification
The bench aims at the direction lock, where a design that copied the written byte blindly would flip the direction mid-transfer, and at the status write-one-to-clear rules, where a plain register would lose the interrupt on a 0 write or let software fake the active flag. It drives an interrupt strobe into the same cycle as a clearing write, which a design giving software priority would lose. It also sends wrong-size and wrong-offset writes, writes with the enable low and run requests with no drive, where a lax design would corrupt a register or emit a start pulse with nothing to receive it.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    localparam int ADDR_W    = 3;
    localparam int SIZE_W    = 3;
    localparam int DATA_W    = 32;
    localparam int REG_BYTES = 1 << ADDR_W;
    localparam int IMG_W     = REG_BYTES * 8;
    localparam int ALIGN_B   = 2;

    localparam logic [ADDR_W-1:0] OFF_CMD   = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_SPLO  = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_SPHI  = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_PTR   = 3'd4;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_CMD,
        WK_STAT,
        WK_PTR,
        WK_SPLO,
        WK_SPHI,
        WK_BAD
    } wr_kind_e;

    typedef struct packed {
        logic cap0;
        logic cap1;
        logic irq;
        logic err;
        logic act;
    } stat_t;

    typedef struct packed {
        logic run;
        logic dir;
    } cmd_t;

    function automatic logic [7:0] pack_stat(stat_t s);
        return {1'b0, s.cap0, s.cap1, 2'b00, s.irq, s.err, s.act};
    endfunction

    function automatic logic [7:0] pack_cmd(cmd_t c);
        return {4'b0000, c.dir, 2'b00, c.run};
    endfunction

    function automatic logic size_ok(logic [SIZE_W-1:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

endpackage

// File: rtl/bmdma_wr_decode.sv
module bmdma_wr_decode
    import bmdma_pkg::*;
(
    input  logic              wr_en,
    input  logic              bm_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output wr_kind_e          kind
);

    always_comb begin
        kind = WK_NONE;
        if (wr_en && bm_en) begin
            kind = WK_BAD;
            if (size == 3'd1) begin
                case (addr)
                    OFF_CMD:  kind = WK_CMD;
                    OFF_SPLO: kind = WK_SPLO;
                    OFF_STAT: kind = WK_STAT;
                    OFF_SPHI: kind = WK_SPHI;
                    default:  kind = WK_BAD;
                endcase
            end else if (size == 3'd4 && addr == OFF_PTR) begin
                kind = WK_PTR;
            end
        end
    end

endmodule

// File: rtl/bmdma_cmd_ctl.sv
module bmdma_cmd_ctl
    import bmdma_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  wr_kind_e kind,
    input  logic     w_run,
    input  logic     w_dir,
    input  logic     drive_present,
    input  logic     done_strobe,
    output cmd_t     cmd_q,
    output logic     act_q,
    output logic     start_q,
    output logic     abort_q,
    output logic     err_q
);

    cmd_t cmd_n;
    logic act_n, start_n, abort_n, err_n;

    always_comb begin
        cmd_n   = cmd_q;
        act_n   = act_q;
        start_n = 1'b0;
        abort_n = 1'b0;
        err_n   = (kind == WK_BAD);
        if (kind == WK_CMD) begin
            if (!cmd_q.run)
                cmd_n.dir = w_dir;
            if (!cmd_q.run && w_run) begin
                if (drive_present) begin
                    cmd_n.run = 1'b1;
                    act_n     = 1'b1;
                    start_n   = 1'b1;
                end else begin
                    err_n = 1'b1;
                end
            end else if (cmd_q.run && !w_run) begin
                cmd_n.run = 1'b0;
                act_n     = 1'b0;
                abort_n   = 1'b1;
            end
        end
        if (done_strobe) begin
            cmd_n.run = 1'b0;
            act_n     = 1'b0;
            start_n   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            act_q   <= 1'b0;
            start_q <= 1'b0;
            abort_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            cmd_q   <= cmd_n;
            act_q   <= act_n;
            start_q <= start_n;
            abort_q <= abort_n;
            err_q   <= err_n;
        end
    end

    p_start_sets_active_r3: assert property (@(posedge clk) disable iff (rst)
        start_q |-> act_q && cmd_q.run);

    p_abort_clears_active_r4: assert property (@(posedge clk) disable iff (rst)
        abort_q |-> !act_q && !cmd_q.run);

    p_dir_locked_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_q.run |=> cmd_q.dir == $past(cmd_q.dir));

    p_done_stops_r8: assert property (@(posedge clk) disable iff (rst)
        done_strobe |=> !cmd_q.run && !act_q && !start_q);

    p_no_drive_no_start_r11: assert property (@(posedge clk) disable iff (rst)
        !drive_present && kind == WK_CMD |=> !start_q);

endmodule

// File: rtl/bmdma_stat_reg.sv
module bmdma_stat_reg
    import bmdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wr_kind_e   kind,
    input  logic [1:0] w_caps,
    input  logic       w_clr_irq,
    input  logic       w_clr_err,
    input  logic       done_strobe,
    input  logic       intr_strobe,
    output logic [1:0] caps_q,
    output logic       irq_q,
    output logic       err_q
);

    logic       wr_hit;
    logic [1:0] caps_n;
    logic       irq_n, err_n;

    assign wr_hit = (kind == WK_STAT);

    always_comb begin
        caps_n = wr_hit ? w_caps : caps_q;
        irq_n  = irq_q & ~(wr_hit & w_clr_irq);
        err_n  = err_q & ~(wr_hit & w_clr_err);
        if (done_strobe || intr_strobe)
            irq_n = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            caps_q <= 2'b11;
            irq_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            caps_q <= caps_n;
            irq_q  <= irq_n;
            err_q  <= err_n;
        end
    end

    p_irq_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (done_strobe || intr_strobe) |=> irq_q);

    p_zero_keeps_irq_r6: assert property (@(posedge clk) disable iff (rst)
        irq_q && !(wr_hit && w_clr_irq) |=> irq_q);

    p_err_never_rises_r6: assert property (@(posedge clk) disable iff (rst)
        !err_q |=> !err_q);

endmodule

// File: rtl/bmdma_chan_regs.sv
module bmdma_chan_regs
    import bmdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bm_en,
    input  logic              drive_present,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [SIZE_W-1:0] acc_size,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              done_strobe,
    input  logic              intr_strobe,
    output logic              dma_start,
    output logic              dma_abort,
    output logic [DATA_W-1:0] dma_ptr,
    output logic              dma_dir,
    output logic              acc_err
);

    wr_kind_e          kind;
    cmd_t              cmd_q;
    stat_t             stat_v;
    logic              act_q, irq_q, derr_q;
    logic [1:0]        caps_q;
    logic [7:0]        sp_lo_q, sp_hi_q;
    logic [DATA_W-1:0] ptr_q, ptr_n;
    logic [IMG_W-1:0]  image, shifted;
    logic [ADDR_W:0]   rd_end;
    logic              rd_ok;
    logic [DATA_W-1:0] rd_mask;

    bmdma_wr_decode u_dec (
        .wr_en (wr_en),
        .bm_en (bm_en),
        .addr  (acc_addr),
        .size  (acc_size),
        .kind  (kind)
    );

    bmdma_cmd_ctl u_cmd (
        .clk           (clk),
        .rst           (rst),
        .kind          (kind),
        .w_run         (wr_data[0]),
        .w_dir         (wr_data[3]),
        .drive_present (drive_present),
        .done_strobe   (done_strobe),
        .cmd_q         (cmd_q),
        .act_q         (act_q),
        .start_q       (dma_start),
        .abort_q       (dma_abort),
        .err_q         (acc_err)
    );

    bmdma_stat_reg u_stat (
        .clk         (clk),
        .rst         (rst),
        .kind        (kind),
        .w_caps      (wr_data[6:5]),
        .w_clr_irq   (wr_data[2]),
        .w_clr_err   (wr_data[1]),
        .done_strobe (done_strobe),
        .intr_strobe (intr_strobe),
        .caps_q      (caps_q),
        .irq_q       (irq_q),
        .err_q       (derr_q)
    );

    // pointer is always word aligned; low bits are masked on the way in
    always_comb begin
        ptr_n = wr_data;
        ptr_n[ALIGN_B-1:0] = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            sp_lo_q <= '0;
            sp_hi_q <= '0;
        end else begin
            if (kind == WK_PTR)  ptr_q   <= ptr_n;
            if (kind == WK_SPLO) sp_lo_q <= wr_data[7:0];
            if (kind == WK_SPHI) sp_hi_q <= wr_data[7:0];
        end
    end

    assign stat_v = '{cap0: caps_q[1], cap1: caps_q[0], irq: irq_q,
                      err: derr_q, act: act_q};

    assign image   = {ptr_q, sp_hi_q, pack_stat(stat_v), sp_lo_q, pack_cmd(cmd_q)};
    assign shifted = image >> {acc_addr, 3'b000};
    assign rd_end  = {1'b0, acc_addr} + {1'b0, acc_size};
    assign rd_ok   = size_ok(acc_size) && (rd_end <= ADDR_W'(0) + (ADDR_W+1)'(REG_BYTES));

    always_comb begin
        case (acc_size)
            3'd1:    rd_mask = 32'h0000_00FF;
            3'd2:    rd_mask = 32'h0000_FFFF;
            default: rd_mask = 32'hFFFF_FFFF;
        endcase
        rd_data = rd_ok ? (shifted[DATA_W-1:0] & rd_mask) : '0;
    end

    assign dma_ptr = ptr_q;
    assign dma_dir = cmd_q.dir;

    p_disabled_write_r10: assert property (@(posedge clk) disable iff (rst)
        !bm_en |=> $stable(ptr_q) && $stable(sp_lo_q) && $stable(sp_hi_q) && !acc_err);

    p_bad_write_keeps_r11: assert property (@(posedge clk) disable iff (rst)
        kind == WK_BAD |=> acc_err && $stable(ptr_q) && $stable(sp_lo_q) && $stable(sp_hi_q));

    p_ptr_aligned_r7: assert property (@(posedge clk) disable iff (rst)
        kind == WK_PTR |=> ptr_q[ALIGN_B-1:0] == '0 && ptr_q[DATA_W-1:ALIGN_B] == $past(wr_data[DATA_W-1:ALIGN_B]));

    p_start_carries_ptr_r3: assert property (@(posedge clk) disable iff (rst)
        dma_start |-> $stable(ptr_q));

endmodule

// File: tb/sim_bmdma_chan_regs.sv
`timescale 1ns/1ps
module sim_bmdma_chan_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bm_en = 1'b1;
    logic        drive_present = 1'b1;
    logic [2:0]  acc_addr = '0;
    logic [2:0]  acc_size = 3'd1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        done_strobe = 1'b0;
    logic        intr_strobe = 1'b0;
    logic        dma_start, dma_abort, dma_dir, acc_err;
    logic [31:0] dma_ptr;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bmdma_chan_regs u0 (
        .clk(clk), .rst(rst), .bm_en(bm_en), .drive_present(drive_present),
        .acc_addr(acc_addr), .acc_size(acc_size), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .done_strobe(done_strobe),
        .intr_strobe(intr_strobe), .dma_start(dma_start), .dma_abort(dma_abort),
        .dma_ptr(dma_ptr), .dma_dir(dma_dir), .acc_err(acc_err)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [2:0] s, input logic [31:0] d,
                      input bit with_irq);
        @(negedge clk);
        acc_addr = a; acc_size = s; wr_data = d; wr_en = 1'b1;
        intr_strobe = with_irq;
        @(posedge clk);
        #1;
        wr_en = 1'b0; intr_strobe = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [2:0] s, output logic [31:0] d);
        @(negedge clk);
        acc_addr = a; acc_size = s;
        #1;
        d = rd_data;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, 3'd4, v); chk("R1 low word", v, 32'h0060_0000);
        rd(3'd4, 3'd4, v); chk("R1 pointer", v, 32'h0);
        chk("R1 no pulses", {dma_start, dma_abort, acc_err}, 32'h0);
    endtask

    task automatic t_pointer();
        logic [31:0] v;
        wr(3'd4, 3'd4, 32'h1234_5677, 1'b0);
        rd(3'd4, 3'd4, v); chk("R7 aligned pointer", v, 32'h1234_5674);
        chk("R7 dma_ptr", dma_ptr, 32'h1234_5674);
    endtask

    task automatic t_reads();
        logic [31:0] v;
        rd(3'd2, 3'd2, v); chk("R2 two-byte status", v, 32'h0000_0060);
        rd(3'd5, 3'd1, v); chk("R2 byte 5", v, 32'h0000_0056);
        rd(3'd6, 3'd2, v); chk("R2 top half", v, 32'h0000_1234);
        rd(3'd7, 3'd2, v); chk("R2 overrun read", v, 32'h0);
        rd(3'd0, 3'd3, v); chk("R2 size three", v, 32'h0);
    endtask

    task automatic t_spare();
        logic [31:0] v;
        wr(3'd1, 3'd1, 32'h0000_00A5, 1'b0);
        wr(3'd3, 3'd1, 32'h0000_003C, 1'b0);
        rd(3'd0, 3'd4, v); chk("R12 spare bytes", v, 32'h3C60_A500);
    endtask

    task automatic t_start_lock_stop();
        logic [31:0] v;
        wr(3'd0, 3'd1, 32'h09, 1'b0);
        chk("R3 start pulse", dma_start, 1);
        chk("R3 start ptr", dma_ptr, 32'h1234_5674);
        chk("R3 dir", dma_dir, 1);
        tick();
        chk("R3 single pulse", dma_start, 0);
        rd(3'd2, 3'd1, v); chk("R3 active set", v, 32'h61);
        wr(3'd0, 3'd1, 32'h01, 1'b0);
        chk("R5 no second start", dma_start, 0);
        rd(3'd0, 3'd1, v); chk("R5 dir locked", v, 32'h09);
        wr(3'd2, 3'd1, 32'h00, 1'b0);
        rd(3'd2, 3'd1, v); chk("R6 caps clear, active kept", v, 32'h01);
        wr(3'd2, 3'd1, 32'hFF, 1'b0);
        rd(3'd2, 3'd1, v); chk("R6 caps set, reserved zero", v, 32'h61);
        wr(3'd0, 3'd1, 32'h08, 1'b0);
        chk("R4 abort pulse", dma_abort, 1);
        tick();
        chk("R4 single abort", dma_abort, 0);
        rd(3'd2, 3'd1, v); chk("R4 active cleared", v, 32'h60);
        wr(3'd0, 3'd1, 32'h00, 1'b0);
        rd(3'd0, 3'd1, v); chk("R3 dir free when idle", v, 32'h00);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        @(negedge clk); intr_strobe = 1'b1;
        tick(); intr_strobe = 1'b0;
        rd(3'd2, 3'd1, v); chk("R9 strobe sets irq", v, 32'h64);
        wr(3'd2, 3'd1, 32'h60, 1'b0);
        rd(3'd2, 3'd1, v); chk("R6 zero keeps irq", v, 32'h64);
        wr(3'd2, 3'd1, 32'h66, 1'b0);
        rd(3'd2, 3'd1, v); chk("R6 one clears irq", v, 32'h60);
        wr(3'd2, 3'd1, 32'h64, 1'b1);
        rd(3'd2, 3'd1, v); chk("R9 set beats clear", v, 32'h64);
        wr(3'd2, 3'd1, 32'h64, 1'b0);
        rd(3'd2, 3'd1, v); chk("R9 cleared after", v, 32'h60);
    endtask

    task automatic t_done();
        logic [31:0] v;
        wr(3'd0, 3'd1, 32'h01, 1'b0);
        chk("R3 restart", dma_start, 1);
        @(negedge clk); done_strobe = 1'b1;
        tick(); done_strobe = 1'b0;
        chk("R8 no abort", dma_abort, 0);
        rd(3'd0, 3'd1, v); chk("R8 run cleared", v, 32'h00);
        rd(3'd2, 3'd1, v); chk("R8 irq set, idle", v, 32'h64);
        wr(3'd2, 3'd1, 32'h64, 1'b0);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        bm_en = 1'b0;
        wr(3'd4, 3'd4, 32'h0, 1'b0);
        chk("R10 no error", acc_err, 0);
        wr(3'd0, 3'd1, 32'h01, 1'b0);
        chk("R10 no start", dma_start, 0);
        rd(3'd4, 3'd4, v); chk("R10 pointer kept", v, 32'h1234_5674);
        rd(3'd0, 3'd1, v); chk("R10 cmd kept", v, 32'h00);
        bm_en = 1'b1;
    endtask

    task automatic t_errors();
        logic [31:0] v;
        wr(3'd0, 3'd2, 32'h0000_0009, 1'b0);
        chk("R11 wide cmd error", acc_err, 1);
        rd(3'd0, 3'd1, v); chk("R11 cmd unchanged", v, 32'h00);
        wr(3'd4, 3'd1, 32'h0000_00FF, 1'b0);
        chk("R11 byte ptr error", acc_err, 1);
        tick();
        chk("R11 error one cycle", acc_err, 0);
        rd(3'd4, 3'd4, v); chk("R11 ptr unchanged", v, 32'h1234_5674);
        drive_present = 1'b0;
        wr(3'd0, 3'd1, 32'h01, 1'b0);
        chk("R11 no drive error", acc_err, 1);
        chk("R11 no drive start", dma_start, 0);
        rd(3'd0, 3'd1, v); chk("R11 run stays 0", v, 32'h00);
        drive_present = 1'b1;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_pointer();
        t_reads();
        t_spare();
        t_start_lock_stop();
        t_irq();
        t_done();
        t_disabled();
        t_errors();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule